// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one memory burst, one address per clock. A start strobe loads a starting column, a burst-length code and an order bit. From the next clock on, the block emits the column of each beat, a valid flag and a flag that marks the final beat. Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that many columns and wrap at its edge. They follow either a counting order or an XOR (interleaved) order. A full-row burst counts through the whole row, wraps from the top column to column 0, and runs until a stop input ends it.

The row width comes from a device-width parameter: 0 gives 10 column bits (1024 columns), 1 gives 9 bits (512) and 2 gives 8 bits (256). A new start strobe always wins over a burst in progress. A full-row request with the interleaved order is run in counting order and flagged for one cycle.

Top module: `burst_col_seq`

## Requirements
- R1: A start strobe sampled at a rising edge makes `valid_o` high after that edge, with `col_o` equal to the starting column as the first beat.
- R2: Length code 0 (one beat) gives exactly one beat, the starting column, with `last_o` high, whatever the value of `itlv_i`.
- R3: In counting order (`itlv_i`=0) with code 1, 2 or 3 (2, 4 or 8 beats, N), beat k has low log2(N) bits equal to (start low bits + k) mod N. The bits above them equal those of the starting column on every beat.
- R4: In interleaved order (`itlv_i`=1) with code 1, 2 or 3, beat k has low log2(N) bits equal to start low bits XOR k, and the upper bits are unchanged.
- R5: A fixed burst of N beats gives exactly N consecutive valid beats. `last_o` is high only with the N-th beat, and `valid_o` drops on the next cycle unless a new start arrives.
- R6: Code 4 (full row) outputs the starting column and then adds one per beat, modulo the row size, passing through the starting column again. `last_o` stays low while `stop_i` is low.
- R7: In a full-row burst, `stop_i` high at a rising edge makes the beat produced at that edge the last one (`last_o` high), after which the burst ends. `stop_i` has no effect on fixed bursts or on idle cycles.
- R8: A full-row request with `itlv_i`=1 runs in counting order, and `mode_err_o` is high for exactly the first beat of that burst.
- R9: A start strobe during a running burst drops the rest of that burst, and the new burst's first beat appears right after the strobe's edge.
- R10: After synchronous reset, `valid_o`, `last_o` and `mode_err_o` are low.
- R11: Length codes 5, 6 and 7 behave like code 0: a single beat with `last_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Loads a new burst at this edge |
| col_start_i | input | COL_W | Starting column of the burst |
| blen_i | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 4=full row |
| itlv_i | input | 1 | Order: 0 counting, 1 interleaved |
| stop_i | input | 1 | Ends a full-row burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | The current beat is the final one |
| mode_err_o | output | 1 | Full row was asked with interleaved order |

## Verification
The assertions check rules that apply on every cycle. `last_o` never appears without a beat. A burst never stops before its last beat and never continues past it. The upper column bits stay fixed during a fixed burst, a full row steps by one, `last_o` stays low in a full row until stop is given, and the error flag appears only with a beat. The exact visiting order of each length and order bit, the wrap points and the row wrap through column 0 can only be shown by the bench's scenarios. The same holds for the error beat, for stop being ignored in fixed bursts, for aborts and for the unused length codes; the bench compares each beat against a queue of expected columns.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    BLEN_1   = 3'd0,
    BLEN_2   = 3'd1,
    BLEN_4   = 3'd2,
    BLEN_8   = 3'd3,
    BLEN_ROW = 3'd4
  } blen_e;

  // device-width selector to column address width
  function automatic int col_width(input int dev_sel);
    case (dev_sel)
      0:       return 10;
      1:       return 9;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       blen_i,
  input  logic             itlv_i,
  output logic [COL_W-1:0] mask_o,
  output logic             row_o,
  output logic             itlv_o,
  output logic             err_o
);
  import burst_pkg::*;

  always_comb begin
    row_o  = 1'b0;
    mask_o = '0;
    case (blen_i)
      BLEN_2:   mask_o = COL_W'(1);
      BLEN_4:   mask_o = COL_W'(3);
      BLEN_8:   mask_o = COL_W'(7);
      BLEN_ROW: begin
        mask_o = '1;
        row_o  = 1'b1;
      end
      default:  mask_o = '0;
    endcase
    itlv_o = itlv_i & ~row_o;
    err_o  = itlv_i & row_o;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             itlv_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    low   = itlv_i ? (base_i ^ beat_i) : (base_i + beat_i);
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] base_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic             itlv_in,
  input  logic             row_in,
  output logic [COL_W-1:0] base_n,
  output logic [COL_W-1:0] mask_n,
  output logic             itlv_n,
  output logic [COL_W-1:0] beat_n,
  output logic             valid_n,
  output logic             valid_q,
  output logic             last_q,
  output logic             row_q,
  output logic [COL_W-1:0] mask_q
);
  logic [COL_W-1:0] base_q, beat_q;
  logic             itlv_q, row_n, last_n, advance;

  assign advance = valid_q & ~last_q;

  always_comb begin
    base_n  = base_q;
    mask_n  = mask_q;
    itlv_n  = itlv_q;
    row_n   = row_q;
    beat_n  = beat_q;
    valid_n = 1'b0;
    last_n  = 1'b0;
    if (start_i) begin
      base_n  = base_in;
      mask_n  = mask_in;
      itlv_n  = itlv_in;
      row_n   = row_in;
      beat_n  = '0;
      valid_n = 1'b1;
      last_n  = ~row_in & (mask_in == '0);
    end else if (advance) begin
      beat_n  = beat_q + COL_W'(1);
      valid_n = 1'b1;
      last_n  = row_q ? stop_i : (beat_n == mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      itlv_q  <= 1'b0;
      row_q   <= 1'b0;
      beat_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      base_q  <= base_n;
      mask_q  <= mask_n;
      itlv_q  <= itlv_n;
      row_q   <= row_n;
      beat_q  <= beat_n;
      valid_q <= valid_n;
      last_q  <= last_n;
    end
  end

  // R5
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    last_q |-> valid_q);

  // R5
  burst_continues_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !last_q) |=> valid_q);

  // R5
  burst_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && last_q && !start_i) |=> !valid_q);

  // R6
  row_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !last_q && row_q && !start_i && !stop_i) |=> !last_q);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int DEV_W = 2,
  localparam int COL_W = burst_pkg::col_width(DEV_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_start_i,
  input  logic [2:0]       blen_i,
  input  logic             itlv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             mode_err_o
);
  logic [COL_W-1:0] dec_mask, base_n, mask_n, beat_n, mask_q, col_n;
  logic             dec_row, dec_itlv, dec_err, itlv_n, valid_n, row_q;

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .blen_i (blen_i),
    .itlv_i (itlv_i),
    .mask_o (dec_mask),
    .row_o  (dec_row),
    .itlv_o (dec_itlv),
    .err_o  (dec_err)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .stop_i  (stop_i),
    .base_in (col_start_i),
    .mask_in (dec_mask),
    .itlv_in (dec_itlv),
    .row_in  (dec_row),
    .base_n  (base_n),
    .mask_n  (mask_n),
    .itlv_n  (itlv_n),
    .beat_n  (beat_n),
    .valid_n (valid_n),
    .valid_q (valid_o),
    .last_q  (last_o),
    .row_q   (row_q),
    .mask_q  (mask_q)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base_n),
    .mask_i (mask_n),
    .itlv_i (itlv_n),
    .beat_i (beat_n),
    .col_o  (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o      <= '0;
      mode_err_o <= 1'b0;
    end else begin
      if (valid_n) col_o <= col_n;
      mode_err_o <= start_i & dec_err;
    end
  end

  // R3
  upper_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !row_q && !start_i)
      |=> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && row_q && !start_i)
      |=> (col_o == $past(col_o) + COL_W'(1)));

  // R8
  err_with_beat_chk: assert property (@(posedge clk) disable iff (rst)
    mode_err_o |-> valid_o);

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_err_o && !start_i) |=> !mode_err_o);

endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int CW   = 8;
  localparam int COLS = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [CW-1:0] col_start_i = '0;
  logic [2:0]    blen_i = '0;
  logic          itlv_i = 1'b0;
  logic          stop_i = 1'b0;
  logic [CW-1:0] col_o;
  logic          valid_o, last_o, mode_err_o;

  typedef struct {
    int    col;
    bit    last;
    bit    err;
    string tag;
  } item_t;

  item_t exp_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;

  burst_col_seq #(.DEV_W(2)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .col_start_i(col_start_i),
    .blen_i(blen_i), .itlv_i(itlv_i), .stop_i(stop_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .mode_err_o(mode_err_o)
  );

  always #10 clk = ~clk;

  function automatic int beats_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int n, input bit il, input int k);
    int base, low;
    if (n == 1) return s;
    base = s - (s % n);
    low  = il ? ((s % n) ^ k) : (((s % n) + k) % n);
    return base + low;
  endfunction

  task automatic push(input int c, input bit l, input bit e, input string t);
    item_t it;
    it.col = c; it.last = l; it.err = e; it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic fire(input int s, input int code, input bit il);
    col_start_i = CW'(s);
    blen_i      = 3'(code);
    itlv_i      = il;
    start_i     = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
  endtask

  task automatic fixed_burst(input int s, input int code, input bit il, input string t);
    int n = beats_of(code);
    for (int k = 0; k < n; k++)
      push(exp_col(s, n, il, k), (k == n - 1), 1'b0, t);
    fire(s, code, il);
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic row_burst(input int s, input bit il, input int nb, input string t);
    for (int k = 0; k < nb; k++)
      push((s + k) % COLS, (k == nb - 1), il && (k == 0), t);
    fire(s, 4, il);
    repeat (nb - 2) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  task automatic idle_gap(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_chk++;
      if (valid_o || last_o) begin
        n_bad++;
        $display("FAIL %s idle: valid=%0b last=%0b expected valid=0 last=0", t, valid_o, last_o);
      end
    end
  endtask

  // monitor: compares each produced beat against the queue
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 extra beat: col=%0h last=%0b expected no beat", col_o, last_o);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (int'(col_o) != e.col || last_o != e.last || mode_err_o != e.err) begin
          n_bad++;
          $display("FAIL %s: col=%0h last=%0b err=%0b expected col=%0h last=%0b err=%0b",
                   e.tag, col_o, last_o, mode_err_o, e.col, e.last, e.err);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL R5 watchdog: cycles=%0d expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if (valid_o || last_o || mode_err_o) begin
      n_bad++;
      $display("FAIL R10: valid=%0b last=%0b err=%0b expected 0 0 0", valid_o, last_o, mode_err_o);
    end
    rst = 1'b0;
    idle_gap(2, "R10");

    // R2: single beat, order bit ignored; R1 first beat timing
    fixed_burst(8'h37, 0, 1'b1, "R2");
    idle_gap(2, "R5");
    fixed_burst(8'h41, 1, 1'b0, "R3");
    fixed_burst(8'h5E, 2, 1'b0, "R3");
    fixed_burst(8'h95, 3, 1'b0, "R3");
    idle_gap(2, "R5");
    // R4: interleaved orders
    fixed_burst(8'hC5, 3, 1'b1, "R4");
    fixed_burst(8'h12, 2, 1'b1, "R4");
    fixed_burst(8'h7B, 1, 1'b1, "R4");
    idle_gap(3, "R5");

    // R11: unused length code acts as one beat
    fixed_burst(8'hA6, 6, 1'b0, "R11");
    idle_gap(2, "R11");

    // R7: stop has no effect on a fixed burst
    stop_i = 1'b1;
    fixed_burst(8'h4D, 2, 1'b0, "R7");
    idle_gap(2, "R7");
    stop_i = 1'b0;

    // R6 / R7: full row wrapping past the top column, then stopped
    row_burst(250, 1'b0, 10, "R6");
    idle_gap(2, "R7");
    // R8: full row with interleaved request
    row_burst(3, 1'b1, 5, "R8");
    idle_gap(2, "R8");
    // R6: long row passing through the start column again
    row_burst(16, 1'b0, COLS + 3, "R6");
    idle_gap(2, "R6");

    // R9: abort an 8-beat burst after three beats
    for (int k = 0; k < 3; k++) push(8'h20 + k, 1'b0, 1'b0, "R9");
    fire(8'h20, 3, 1'b0);
    repeat (2) @(negedge clk);
    fixed_burst(8'h33, 1, 1'b1, "R9");
    idle_gap(3, "R9");

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R5: pending beats=%0d expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule